// File: doc/BRIEF.md
# Staggered Two-Fabric Slot Sequencer

This block produces the crossbar settings used in each time slot by both fabrics of an N-port load-balanced two-stage switch. In the first fabric, every input is joined to one middle port. The whole set of connections rotates by one position on each slot tick, so that each input meets every middle port once per period of N slots. The second fabric takes its pattern from the first. If a middle port feeds output k in one slot, then input k is joined to that same middle port in the following slot. Occupancy information from a middle port can therefore travel on the data bound for output k and arrive at input k just when that input needs it.

The derived pattern has two useful results. Each input always reaches the same anchor output, through whichever middle port it currently uses. Each middle port also walks the outputs in descending order, so the block can announce the output each middle port will serve in the following slot. Schedulers use that look-ahead to avoid underflow. The slot counter and all settings are registered, and they move only on the slot tick. The settings are packed per port, with port p occupying bits [p*W +: W], where W = log2(N).

Top module: `stagseq_top`

## Requirements
- R1: A synchronous reset sets the slot index to 0. It sets firstMid for input i to i, secondOut for middle port j to (j-1) mod N, and nextOut for middle port j to (j-2) mod N.
- R2: In slot t, input i is connected to middle port (i+t) mod N. Here t is the number of ticks since reset, taken modulo N.
- R3: In slot t, middle port j is connected to output (j-t-1) mod N.
- R4: Staggered symmetry: if middle port j feeds output k in one slot, then after the next tick firstMid of input k equals j.
- R5: anchorOut for input i is the constant (i-1) mod N. In every slot, the second-fabric output of the middle port that input i uses equals that anchor.
- R6: nextOut for middle port j equals (secondOut - 1) mod N. It equals the value secondOut takes after the next tick.
- R7: In a cycle without a tick, every output keeps its value.
- R8: In every slot, both firstMid and secondOut are permutations of 0..N-1.
- R9: A tick that arrives while reset is asserted is ignored, and reset wins.
- R10: The slot index goes up by one per tick and wraps from N-1 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| slotTick | input | 1 | Advance to the next slot |
| slotIdx | output | W | Current slot number modulo N |
| firstMid | output | N*W | Per input: the middle port it connects to |
| secondOut | output | N*W | Per middle port: the output it connects to |
| nextOut | output | N*W | Per middle port: the output it will serve in the next slot |
| anchorOut | output | N*W | Per input: its fixed anchor output |

## Verification
The bench runs the block for more than three full periods. Its tick pattern mixes back-to-back ticks, gaps, a tick held together with reset and a reset in the middle of a run. This exposes a counter that does not wrap at N, or that lets a tick through during reset, because every later slot then shows shifted settings. A second fabric that is one slot off in phase, or that counts upward instead of downward, breaks the check that compares each output with the previous slot's first-fabric setting. A look-ahead value with the wrong offset disagrees with the setting seen after the next tick. Any stuck or duplicated port shows up as a failed permutation check.

// File: rtl/stagseq_pkg.sv
package stagseq_pkg;
  // Strobes from the slot control to the configuration datapath
  typedef struct packed {
    logic clear;    // restart the sequence at slot 0
    logic advance;  // move every setting to the next slot
  } seqStrobe_t;
endpackage

// File: rtl/stagseq_ctrl.sv
module stagseq_ctrl
  import stagseq_pkg::*;
#(
  parameter int N = 8,
  localparam int W = (N > 1) ? $clog2(N) : 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         slotTick,
  output seqStrobe_t   strobe,
  output logic [W-1:0] slotIdx
);

  // Reset takes priority over a tick in the same cycle
  always_comb begin
    strobe.clear   = rst;
    strobe.advance = slotTick && !rst;
  end

  // Slot counter; wraps naturally because N is a power of two
  always_ff @(posedge clk) begin
    if (strobe.clear)        slotIdx <= '0;
    else if (strobe.advance) slotIdx <= slotIdx + W'(1);
  end

  AST_SLOT_RESET: assert property (@(posedge clk) rst |=> slotIdx == '0); // R1
  AST_SLOT_STEP:  assert property (@(posedge clk) disable iff (rst)
                    slotTick |=> slotIdx == $past(slotIdx) + W'(1));   // R10
  AST_SLOT_HOLD:  assert property (@(posedge clk) disable iff (rst)
                    !slotTick |=> $stable(slotIdx));                   // R7
  AST_TICK_MASK:  assert property (@(posedge clk)
                    (rst && slotTick) |-> !strobe.advance);            // R9

endmodule

// File: rtl/stagseq_path.sv
module stagseq_path
  import stagseq_pkg::*;
#(
  parameter int N = 8,
  localparam int W = (N > 1) ? $clog2(N) : 1
) (
  input  logic           clk,
  input  seqStrobe_t     strobe,
  output logic [N*W-1:0] firstMid,
  output logic [N*W-1:0] secondOut,
  output logic [N*W-1:0] nextOut,
  output logic [N*W-1:0] anchorOut
);

  logic [W-1:0] midReg  [N];
  logic [W-1:0] outReg  [N];
  logic [W-1:0] nextReg [N];

  for (genvar p = 0; p < N; p++) begin : gPort
    localparam logic [W-1:0] MidInit    = W'(p);
    localparam logic [W-1:0] OutInit    = W'(p + N - 1);
    localparam logic [W-1:0] NextInit   = W'(p + 2*N - 2);
    localparam logic [W-1:0] AnchorPort = W'(p + N - 1);

    // First fabric rotates upward by one middle port per slot
    always_ff @(posedge clk) begin
      if (strobe.clear)        midReg[p] <= MidInit;
      else if (strobe.advance) midReg[p] <= midReg[p] + W'(1);
    end

    // Second fabric walks the outputs downward, together with its look-ahead
    always_ff @(posedge clk) begin
      if (strobe.clear) begin
        outReg[p]  <= OutInit;
        nextReg[p] <= NextInit;
      end else if (strobe.advance) begin
        outReg[p]  <= nextReg[p];
        nextReg[p] <= nextReg[p] - W'(1);
      end
    end

    assign firstMid[p*W +: W]  = midReg[p];
    assign secondOut[p*W +: W] = outReg[p];
    assign nextOut[p*W +: W]   = nextReg[p];
    assign anchorOut[p*W +: W] = AnchorPort;

    AST_ANCHOR_PATH: assert property (@(posedge clk) disable iff (strobe.clear)
                       outReg[midReg[p]] == AnchorPort);                      // R5
    AST_LOOKAHEAD:   assert property (@(posedge clk) disable iff (strobe.clear)
                       strobe.advance |=> outReg[p] == $past(nextReg[p]));    // R6
    AST_DESCEND:     assert property (@(posedge clk) disable iff (strobe.clear)
                       strobe.advance |=> outReg[p] == $past(outReg[p]) - W'(1)); // R3

    for (genvar q = 0; q < N; q++) begin : gPair
      if (q > p) begin : gDistinct
        AST_FIRST_PERM:  assert property (@(posedge clk) disable iff (strobe.clear)
                           midReg[p] != midReg[q]);                         // R8
        AST_SECOND_PERM: assert property (@(posedge clk) disable iff (strobe.clear)
                           outReg[p] != outReg[q]);                         // R8
      end
      AST_STAGGER: assert property (@(posedge clk) disable iff (strobe.clear)
                     (strobe.advance && outReg[p] == W'(q)) |=> midReg[q] == W'(p)); // R4
    end
  end

endmodule

// File: rtl/stagseq_top.sv
module stagseq_top
  import stagseq_pkg::*;
#(
  parameter int N = 8,
  localparam int W = (N > 1) ? $clog2(N) : 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           slotTick,
  output logic [W-1:0]   slotIdx,
  output logic [N*W-1:0] firstMid,
  output logic [N*W-1:0] secondOut,
  output logic [N*W-1:0] nextOut,
  output logic [N*W-1:0] anchorOut
);

  seqStrobe_t strobe;

  stagseq_ctrl #(.N(N)) uCtrl (
    .clk      (clk),
    .rst      (rst),
    .slotTick (slotTick),
    .strobe   (strobe),
    .slotIdx  (slotIdx)
  );

  stagseq_path #(.N(N)) uPath (
    .clk       (clk),
    .strobe    (strobe),
    .firstMid  (firstMid),
    .secondOut (secondOut),
    .nextOut   (nextOut),
    .anchorOut (anchorOut)
  );

  // First-fabric input 0 sits on the middle port numbered by the slot
  AST_SLOT_ALIGN: assert property (@(posedge clk) disable iff (rst)
                    firstMid[W-1:0] == slotIdx); // R2

endmodule

// File: tb/stagseq_top_test.sv
module stagseq_top_test;
  localparam int N = 8;
  localparam int W = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic slotTick = 1'b0;
  logic [W-1:0]   slotIdx;
  logic [N*W-1:0] firstMid, secondOut, nextOut, anchorOut;

  always #2.5 clk = ~clk;

  stagseq_top #(.N(N)) uut (
    .clk(clk), .rst(rst), .slotTick(slotTick), .slotIdx(slotIdx),
    .firstMid(firstMid), .secondOut(secondOut), .nextOut(nextOut),
    .anchorOut(anchorOut)
  );

  int errors = 0;
  int checks = 0;
  int modelT = 0;
  bit steppedLast = 0;
  bit resetLast = 0;
  bit havePrev = 0;
  int prevSecond[N];
  int prevFirst[N];
  int prevSlot = 0;
  bit done = 0;

  // Behavioural reference: slot number advanced by the inputs held at each edge
  always @(posedge clk) begin
    steppedLast = slotTick && !rst;
    resetLast = rst;
    if (rst) modelT = 0;
    else if (slotTick) modelT = (modelT + 1) % N;
  end

  function automatic int fld(logic [N*W-1:0] v, int p);
    return int'(v[p*W +: W]);
  endfunction

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic compareAll();
    int maskA, maskB;
    maskA = 0; maskB = 0;
    check(resetLast ? "R1" : "R10", "slotIdx", int'(slotIdx), modelT);
    for (int p = 0; p < N; p++) begin
      check(resetLast ? "R1" : "R2", $sformatf("firstMid[%0d]", p),
            fld(firstMid, p), (p + modelT) % N);
      check(resetLast ? "R1" : "R3", $sformatf("secondOut[%0d]", p),
            fld(secondOut, p), (p - modelT - 1 + 2*N) % N);
      check(resetLast ? "R1" : "R6", $sformatf("nextOut[%0d]", p),
            fld(nextOut, p), (p - modelT - 2 + 2*N) % N);
      check("R5", $sformatf("anchorOut[%0d]", p), fld(anchorOut, p), (p + N - 1) % N);
      check("R5", $sformatf("path of input %0d", p),
            fld(secondOut, fld(firstMid, p)), (p + N - 1) % N);
      maskA |= 1 << fld(firstMid, p);
      maskB |= 1 << fld(secondOut, p);
    end
    check("R8", "first fabric cover", maskA, (1 << N) - 1);
    check("R8", "second fabric cover", maskB, (1 << N) - 1);
    if (havePrev && steppedLast) begin
      for (int j = 0; j < N; j++)
        check("R4", $sformatf("input %0d after middle %0d", prevSecond[j], j),
              fld(firstMid, prevSecond[j]), j);
    end
    if (havePrev && !steppedLast && !resetLast) begin
      check("R7", "slotIdx hold", int'(slotIdx), prevSlot);
      for (int p = 0; p < N; p++) begin
        check("R7", $sformatf("firstMid[%0d] hold", p), fld(firstMid, p), prevFirst[p]);
        check("R7", $sformatf("secondOut[%0d] hold", p), fld(secondOut, p), prevSecond[p]);
      end
    end
    if (havePrev && steppedLast)
      check("R10", "slot step", int'(slotIdx), (prevSlot + 1) % N);
    for (int p = 0; p < N; p++) begin
      prevSecond[p] = fld(secondOut, p);
      prevFirst[p] = fld(firstMid, p);
    end
    prevSlot = int'(slotIdx);
    havePrev = 1;
  endtask

  task automatic cycle(bit r, bit tk);
    @(negedge clk);
    compareAll();
    rst = r;
    slotTick = tk;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=expired expected=finished");
    finishRun();
  end

  initial begin
    rst = 1'b1; slotTick = 1'b1;   // R9: tick held together with reset
    cycle(1, 1);
    cycle(0, 0);
    check("R9", "slot after tick in reset", int'(slotIdx), 0);
    // Three periods of back-to-back ticks, wrapping the counter (R10)
    for (int k = 0; k < 3*N; k++) cycle(0, 1);
    // Sparse ticks with gaps (R7)
    for (int k = 0; k < 2*N; k++) cycle(0, (k % 3) == 0);
    // Reset in mid-run, again with a tick (R1, R9)
    cycle(1, 1);
    cycle(0, 1);
    check("R1", "slot after mid-run reset", int'(slotIdx), 0);
    for (int k = 0; k < N + 3; k++) cycle(0, 1);
    for (int k = 0; k < 6; k++) cycle(0, k[0]);
    cycle(0, 0);
    finishRun();
  end

endmodule